// File: doc/BRIEF.md
# Fault-Tolerant Replica-Checked Multiplier

This block multiplies two 12-bit unsigned operands through two paths at once. The main path forms the full 24-bit product. A second, much smaller multiplier uses only the upper half of each operand. Because it is so small, its result is still correct when the main path misses timing under an aggressively lowered supply. The replica result is shifted up to the weight of the full product. A decision stage then takes the magnitude of the gap between the two results.

If the gap is within a programmable threshold, the main product is forwarded. If the gap is larger, the main result is treated as corrupted and the replica value is forwarded in its place. A flag reports which path supplied each output. The threshold is normally set to the worst gap that truncation alone can produce. For 12-bit operands that gap is 512001, so an error-free main product is never rejected.

A fault input emulates timing failures in simulation. When it is enabled, a supplied mask is XORed into the main product before the comparison. Operands, threshold and fault controls are captured together in an input register. The result leaves through an output register, which gives a fixed latency of two clock edges.

Top module: `ntm_mult_top`

## Requirements
- R1: While reset is asserted and after its release, before any sample arrives, `out_valid`, `product` and `sel_replica` are all zero.
- R2: A sample presented with `in_valid` high at clock edge k produces `out_valid` high after edge k+2, one output per sample, including for back-to-back samples.
- R3: With `fault_en` low and a threshold of at least 512001, `product` equals the exact product `op_a*op_b` and `sel_replica` is 0.
- R4: The replica value is `(op_a[11:6]*op_b[11:6])` shifted left by 12 bits, so its low 12 bits are zero.
- R5: When the gap magnitude is strictly above the threshold, `product` equals the replica value and `sel_replica` is 1.
- R6: With `fault_en` high, the main result is `op_a*op_b` XOR `fault_mask`, and that corrupted value is what gets compared and, if accepted, output. With `fault_en` low, `fault_mask` has no effect.
- R7: When the gap magnitude exactly equals the threshold, the main result is selected (`sel_replica` is 0).
- R8: The threshold is captured with each sample, so samples on consecutive cycles may each use a different threshold.
- R9: A cycle without a new sample drives `out_valid` low, and `product` and `sel_replica` keep their last values.
- R10: A main result below the replica value (negative difference) is judged by its magnitude, in the same way as a positive difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new sample is present on the operand inputs |
| op_a | input | 12 | Multiplicand, unsigned |
| op_b | input | 12 | Multiplier, unsigned |
| thresh | input | 24 | Largest gap that still accepts the main result |
| fault_en | input | 1 | Apply `fault_mask` to the main result |
| fault_mask | input | 24 | Bits flipped in the main result when `fault_en` is set |
| out_valid | output | 1 | `product` and `sel_replica` were updated this cycle |
| product | output | 24 | Corrected product |
| sel_replica | output | 1 | 1 when the replica value was forwarded |

## Verification
Fault emulation and the threshold decision interact in the same cycle. An injected mask changes the gap that the decision judges. The bench creates this by asserting the fault input with masks of different size together with thresholds that sit just on either side of the resulting gap, including exact-equality cases and masks that push the main result below the replica. Each case is judged against a behavioural model that computes the exact product, the corrupted product, the replica value and the selection from integers, cycle by cycle, two edges after the sample.

// File: rtl/ntm_pkg.sv
package ntm_pkg;

  typedef enum logic {
    PICK_MAIN    = 1'b0,
    PICK_REPLICA = 1'b1
  } pick_e;

  // Worst gap between the full product and the upper-half product,
  // for operands of width w split into (w - w/2) upper and w/2 lower bits.
  function automatic longint trunc_err_bound(input int w);
    longint lo_w;
    longint hi_max;
    longint lo_max;
    lo_w   = longint'(w / 2);
    hi_max = (longint'(1) << (w - w / 2)) - 1;
    lo_max = (longint'(1) << lo_w) - 1;
    return 2 * hi_max * lo_max * (longint'(1) << lo_w) + lo_max * lo_max;
  endfunction

endpackage

// File: rtl/ntm_array_mul.sv
module ntm_array_mul #(
  parameter int W = 12
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  logic [PW-1:0] acc [0:W];

  assign acc[0] = '0;

  // One partial-product row per multiplier bit, accumulated row by row.
  for (genvar i = 0; i < W; i++) begin : g_row
    logic [PW-1:0] row;
    assign row        = b[i] ? ({{W{1'b0}}, a} << i) : '0;
    assign acc[i + 1] = acc[i] + row;
  end

  assign p = acc[W];

endmodule

// File: rtl/ntm_replica.sv
module ntm_replica #(
  parameter int OP_W = 12
) (
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  output logic [2*OP_W-1:0] yr
);
  localparam int LO_W  = OP_W / 2;
  localparam int REP_W = OP_W - LO_W;
  localparam int SHIFT = 2 * LO_W;

  logic [2*REP_W-1:0] short_prod;

  ntm_array_mul #(.W(REP_W)) u_short (
    .a (a[OP_W-1:LO_W]),
    .b (b[OP_W-1:LO_W]),
    .p (short_prod)
  );

  // Restore the weight of the dropped lower halves.
  assign yr = {short_prod, {SHIFT{1'b0}}};

endmodule

// File: rtl/ntm_decide.sv
module ntm_decide #(
  parameter int PROD_W = 24
) (
  input  logic [PROD_W-1:0] ya,
  input  logic [PROD_W-1:0] yr,
  input  logic [PROD_W-1:0] th,
  output logic [PROD_W:0]   gap_mag,
  output ntm_pkg::pick_e    choice,
  output logic [PROD_W-1:0] pick
);
  logic signed [PROD_W:0] gap_s;
  logic                   beyond;

  always_comb begin
    gap_s   = $signed({1'b0, ya}) - $signed({1'b0, yr});
    gap_mag = gap_s[PROD_W] ? $unsigned(-gap_s) : $unsigned(gap_s);
    beyond  = gap_mag > {1'b0, th};
    choice  = beyond ? ntm_pkg::PICK_REPLICA : ntm_pkg::PICK_MAIN;
    pick    = (choice == ntm_pkg::PICK_REPLICA) ? yr : ya;
  end

endmodule

// File: rtl/ntm_mult_top.sv
module ntm_mult_top #(
  parameter int OP_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [OP_W-1:0]     op_a,
  input  logic [OP_W-1:0]     op_b,
  input  logic [2*OP_W-1:0]   thresh,
  input  logic                fault_en,
  input  logic [2*OP_W-1:0]   fault_mask,
  output logic                out_valid,
  output logic [2*OP_W-1:0]   product,
  output logic                sel_replica
);
  localparam int PROD_W = 2 * OP_W;
  localparam int LOW_W  = 2 * (OP_W / 2);
  localparam logic [PROD_W-1:0] TRUNC_BOUND =
    PROD_W'(ntm_pkg::trunc_err_bound(OP_W));

  // Input stage
  logic              s_valid;
  logic [OP_W-1:0]   s_a;
  logic [OP_W-1:0]   s_b;
  logic [PROD_W-1:0] s_th;
  logic              s_inj;
  logic [PROD_W-1:0] s_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_a     <= '0;
      s_b     <= '0;
      s_th    <= '0;
      s_inj   <= 1'b0;
      s_mask  <= '0;
    end else begin
      s_valid <= in_valid;
      if (in_valid) begin
        s_a    <= op_a;
        s_b    <= op_b;
        s_th   <= thresh;
        s_inj  <= fault_en;
        s_mask <= fault_mask;
      end
    end
  end

  // Main path with fault emulation
  logic [PROD_W-1:0] ya_clean;
  logic [PROD_W-1:0] fault_term;
  logic [PROD_W-1:0] ya;

  ntm_array_mul #(.W(OP_W)) u_main (
    .a (s_a),
    .b (s_b),
    .p (ya_clean)
  );

  assign fault_term = s_inj ? s_mask : '0;
  assign ya         = ya_clean ^ fault_term;

  // Replica path
  logic [PROD_W-1:0] yr;

  ntm_replica #(.OP_W(OP_W)) u_rep (
    .a  (s_a),
    .b  (s_b),
    .yr (yr)
  );

  // Decision
  logic [PROD_W:0]   gap_mag;
  ntm_pkg::pick_e    choice;
  logic [PROD_W-1:0] pick;

  ntm_decide #(.PROD_W(PROD_W)) u_dec (
    .ya      (ya),
    .yr      (yr),
    .th      (s_th),
    .gap_mag (gap_mag),
    .choice  (choice),
    .pick    (pick)
  );

  // Output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      product     <= '0;
      sel_replica <= 1'b0;
    end else begin
      out_valid <= s_valid;
      if (s_valid) begin
        product     <= pick;
        sel_replica <= (choice == ntm_pkg::PICK_REPLICA);
      end
    end
  end

  // Assertions
  AST_TWO_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);  // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(product) && $stable(sel_replica)));  // R9

  AST_CLEAN_KEEPS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_inj && (s_th >= TRUNC_BOUND)) |=> !sel_replica);  // R3

  AST_EMPTY_MASK_KEEPS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_inj && (s_mask == '0) && (s_th >= TRUNC_BOUND)) |=> !sel_replica);  // R6

  AST_REPLICA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel_replica) |-> (product[LOW_W-1:0] == '0));  // R5

endmodule

// File: tb/ntm_mult_top_bench.sv
module ntm_mult_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint BOUND = 512001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] op_a = '0;
  logic [11:0] op_b = '0;
  logic [23:0] thresh = '0;
  logic        fault_en = 1'b0;
  logic [23:0] fault_mask = '0;
  logic        out_valid;
  logic [23:0] product;
  logic        sel_replica;

  int checks = 0;
  int failures = 0;

  bit     q_v[$];
  longint q_p[$];
  bit     q_s[$];
  string  q_tag[$];
  longint last_p = 0;
  bit     last_s = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ntm_mult_top u_ntm_mult_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_a        (op_a),
    .op_b        (op_b),
    .thresh      (thresh),
    .fault_en    (fault_en),
    .fault_mask  (fault_mask),
    .out_valid   (out_valid),
    .product     (product),
    .sel_replica (sel_replica)
  );

  task automatic compare(input string tag, input bit ev, input longint ep, input bit es);
    checks++;
    if (out_valid !== ev || longint'(product) != ep || sel_replica !== es) begin
      failures++;
      $display("FAIL %s actual valid=%0b product=%0d sel=%0b expected valid=%0b product=%0d sel=%0b",
               tag, out_valid, product, sel_replica, ev, ep, es);
    end
  endtask

  task automatic step(input string tag, input bit v, input longint a, input longint b,
                      input longint th, input bit inj, input longint mask);
    longint exact, ya, yr, gap;
    bit     use_rep;
    if (q_v.size() == 2) begin
      compare(q_tag[0], q_v[0], q_p[0], q_s[0]);
      void'(q_v.pop_front()); void'(q_p.pop_front());
      void'(q_s.pop_front()); void'(q_tag.pop_front());
    end
    in_valid   = v;
    op_a       = a[11:0];
    op_b       = b[11:0];
    thresh     = th[23:0];
    fault_en   = inj;
    fault_mask = mask[23:0];
    if (v) begin
      exact   = a * b;
      ya      = inj ? (exact ^ mask) : exact;
      yr      = ((a / 64) * (b / 64)) * 4096;
      gap     = (ya > yr) ? (ya - yr) : (yr - ya);
      use_rep = gap > th;
      last_p  = use_rep ? yr : ya;
      last_s  = use_rep;
    end
    q_v.push_back(v);
    q_p.push_back(last_p);
    q_s.push_back(last_s);
    q_tag.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 0, 0, 0, 1'b0, 24'hABCDEF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint seed;
    seed = 64'd12345;
    repeat (3) @(negedge clk);
    compare("R1", 1'b0, 0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1", 1'b0, 0, 1'b0);

    // R3 clean products with the truncation bound as threshold
    step("R3", 1, 4095, 4095, BOUND, 0, 0);
    step("R3", 1, 0, 0, BOUND, 0, 0);
    step("R3", 1, 123, 456, BOUND, 0, 0);
    step("R3", 1, 4095, 1, BOUND, 0, 0);
    // R4 replica value with zero threshold
    step("R4", 1, 4095, 4095, 0, 0, 0);
    step("R4", 1, 12'hFC0, 12'h040, 0, 0, 0);
    // R7 equality boundary and one below it (R5)
    step("R7", 1, 4095, 4095, BOUND, 0, 0);
    step("R5", 1, 4095, 4095, BOUND - 1, 0, 0);
    // R6 fault emulation
    step("R6", 1, 1000, 3000, BOUND, 1, 24'h800000);
    step("R6", 1, 1000, 3000, BOUND, 0, 24'h800000);
    step("R6", 1, 1000, 3000, BOUND, 1, 24'h000001);
    step("R6", 1, 2047, 2047, BOUND, 1, 24'h000000);
    // R10 fault pulls main below replica
    step("R10", 1, 12'hFC0, 12'hFC0, BOUND, 1, 24'h800000);
    step("R10", 1, 12'hFC0, 12'hFC0, 24'h7FFFFF, 1, 24'h800000);
    // R8 per-sample threshold on consecutive cycles
    step("R8", 1, 4095, 4095, 0, 0, 0);
    step("R8", 1, 4095, 4095, BOUND, 0, 0);
    step("R8", 1, 4095, 4095, 100, 0, 0);
    // R9 idle gaps hold outputs; mask on idle must not matter
    idle("R9");
    idle("R9");
    idle("R9");
    step("R2", 1, 77, 88, BOUND, 0, 0);
    idle("R9");
    step("R2", 1, 3000, 2500, BOUND, 0, 0);
    step("R2", 1, 2500, 3000, 10, 0, 0);
    // Mixed stream: faults and thresholds around the gap
    for (int i = 0; i < 60; i++) begin
      longint a, b, th, mask;
      bit inj, v;
      seed = (seed * 64'd6364136223846793005 + 64'd1442695040888963407);
      a    = (seed >> 20) & 64'hFFF;
      b    = (seed >> 32) & 64'hFFF;
      mask = (seed >> 8) & 64'hFFFFFF;
      inj  = seed[60];
      v    = seed[61] | seed[62];
      case (seed[58:57])
        2'd0: th = 0;
        2'd1: th = BOUND;
        2'd2: th = (seed >> 40) & 64'hFFFFF;
        default: th = 64'hFFFFFF;
      endcase
      step(inj ? "R6" : "R5", v, a, b, th, inj, mask);
    end
    idle("R9");
    idle("R9");
    idle("R9");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule